// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects 43 level-sensitive interrupt request lines from on-chip sources and hands the processor a single pending interrupt: a request flag, a 4-bit priority level and a 12-bit event code that identifies the source. Software sets source priorities through a small register window. Five priority registers each hold 4-bit fields. Several related sources, such as the channels of one DMA engine or the event lines of one serial port, share a single field, so they rise and fall in priority together. A priority of zero keeps a source silent.

Ten extended sources are also gated by a mask register. Software writes ones at the set address to mask bits and ones at the clear address to unmask them, so it never needs a read-modify-write. Every cycle the arbiter picks the eligible source with the highest priority. On a tie, the lower source index wins. The result is captured in output registers. A two-state machine tracks whether a request is being presented. QUIET moves to RAISED when any source becomes eligible. RAISED returns to QUIET when none is eligible. Both states hold when nothing changes.

Top module: `ipc_ctrl`

## Requirements
- R1: After reset, all priority registers and the mask read back as zero, and irq_o, irq_level_o and irq_code_o are all zero.
- R2: The legacy priority registers sit at byte addresses 0x00, 0x04, 0x08 and 0x0C and use data bits 15:0 (bits 31:16 are neither stored nor read back). Fields are listed from bits 15:12 down to 3:0. Register 0x00 holds timer0, timer1, the timer2 group and the clock group. Register 0x04 holds the watchdog, the refresh group, the serial-1 group and a field that is not stored and reads zero. Register 0x08 holds gpio, the DMA group, the FIFO-serial group and debug. Register 0x0C holds external lines 0, 1, 2 and 3.
- R3: All sources in a group take the priority of the group's shared field. The groups are: timer2 = indices 27-28, clock = 29-31, serial-1 = 32-35, FIFO-serial = 36-39, refresh = 41-42, DMA = 6-14, PCI = 16-22.
- R4: The extended priority register at 0x40 stores bits 15:0 only. Its fields are timer4 in 15:12, timer3 in 11:8, the PCI group in 7:4 and the PCI system error in 3:0. Bits 31:16 read zero.
- R5: The source indices and their event codes are: 0-3 external lines 0x240, 0x2A0, 0x300, 0x360; 4 debug 0x600; 5 gpio 0x620; 6-13 DMA done 0x640, 0x660, 0x680, 0x6A0, 0x780, 0x7A0, 0x7C0, 0x7E0; 14 DMA address error 0x6C0; 15 PCI system error 0xA00; 16-22 PCI 0xAE0, 0xAC0, 0xAA0, 0xA80, 0xA60, 0xA40, 0xA20; 23 timer3 0xB00; 24 timer4 0xB80; 25 timer0 0x400; 26 timer1 0x420; 27-28 timer2 0x440, 0x460; 29-31 clock 0x480, 0x4A0, 0x4C0; 32-35 serial-1 0x4E0, 0x500, 0x520, 0x540; 36-39 FIFO-serial 0x700, 0x720, 0x740, 0x760; 40 watchdog 0x560; 41-42 refresh 0x580, 0x5A0.
- R6: A source whose priority field is zero never raises irq_o, even while its request is high.
- R7: A one written at address 0x80 masks the matching bits, and a one written at 0xA0 unmasks them. Both addresses read back the 10-bit mask zero-extended. The bit map is: 9 timer4, 8 timer3, 7 to 1 source indices 16 to 22, 0 source 15. A masked source is ignored. The mask has no effect on the other sources.
- R8: The winner is the eligible source with the largest priority. Among equal priorities, the lowest source index wins.
- R9: The outputs are registered. A change of requests or registers is seen on the outputs at the next clock edge. Requests are levels, so irq_o drops one cycle after the last eligible request is removed.
- R10: A read from an unmapped address returns zero, and a write to one changes no register.
- R11: While irq_o is low, irq_level_o and irq_code_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 43 | Level request per source index |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt pending |
| irq_level_o | output | 4 | Priority of the winning source |
| irq_code_o | output | 12 | Event code of the winning source |

## Verification
The bench targets several corner cases and names the failure each one catches. Equal-priority ties inside one group and across groups would expose a scan that prefers higher indices, because it would return the wrong event code. Masking the system-error source while external line 0 is also requesting would show a dead mask, since the error code would still come out, and setting every mask bit while timer0 requests would catch a mask that leaks onto legacy sources. Writes of all-ones data check that the unused field and upper halves stay zero, priority-zero and unmapped-address cases check that nothing is raised or stored, and a one-cycle latency probe catches an extra or missing output register.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int NUM_SRC     = 43;
    localparam int PRIO_W      = 4;
    localparam int CODE_W      = 12;
    localparam int ADDR_W      = 8;
    localparam int NUM_LEG     = 4;
    localparam int FLD_PER_REG = 4;
    localparam int REG_W       = FLD_PER_REG * PRIO_W;
    localparam int NUM_FIELDS  = (NUM_LEG + 1) * FLD_PER_REG;
    localparam int EXT_FBASE   = NUM_LEG * FLD_PER_REG;
    localparam int MASK_W      = 10;
    localparam int IDX_W       = $clog2(NUM_SRC);

    localparam logic [ADDR_W-1:0] ADDR_LEG_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_EXT      = 8'h40;
    localparam logic [ADDR_W-1:0] ADDR_MSET     = 8'h80;
    localparam logic [ADDR_W-1:0] ADDR_MCLR     = ADDR_MSET + 8'h20;

    typedef enum logic {
        ST_QUIET,
        ST_RAISED
    } ipc_state_e;

    // Bits of each legacy register that hold storage (unused field dropped).
    function automatic logic [REG_W-1:0] leg_keep(input int k);
        return (k == 1) ? 16'hFFF0 : 16'hFFFF;
    endfunction

    // Shared field index: register * 4 + slot, slot 0 = bits 15:12.
    function automatic int src_field(input int idx);
        if (idx inside {[0:3]})   return 12 + idx;
        if (idx == 4)             return 11;
        if (idx == 5)             return 8;
        if (idx inside {[6:14]})  return 9;
        if (idx == 15)            return EXT_FBASE + 3;
        if (idx inside {[16:22]}) return EXT_FBASE + 2;
        if (idx == 23)            return EXT_FBASE + 1;
        if (idx == 24)            return EXT_FBASE + 0;
        if (idx == 25)            return 0;
        if (idx == 26)            return 1;
        if (idx inside {[27:28]}) return 2;
        if (idx inside {[29:31]}) return 3;
        if (idx inside {[32:35]}) return 6;
        if (idx inside {[36:39]}) return 10;
        if (idx == 40)            return 4;
        return 5;
    endfunction

    // Mask bit gating a source, or -1 when the source is not maskable.
    function automatic int src_mask_bit(input int idx);
        if (idx == 24)            return 9;
        if (idx == 23)            return 8;
        if (idx inside {[16:22]}) return 23 - idx;
        if (idx == 15)            return 0;
        return -1;
    endfunction

    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            0:  return 12'h240;  1:  return 12'h2A0;
            2:  return 12'h300;  3:  return 12'h360;
            4:  return 12'h600;  5:  return 12'h620;
            6:  return 12'h640;  7:  return 12'h660;
            8:  return 12'h680;  9:  return 12'h6A0;
            10: return 12'h780;  11: return 12'h7A0;
            12: return 12'h7C0;  13: return 12'h7E0;
            14: return 12'h6C0;  15: return 12'hA00;
            16: return 12'hAE0;  17: return 12'hAC0;
            18: return 12'hAA0;  19: return 12'hA80;
            20: return 12'hA60;  21: return 12'hA40;
            22: return 12'hA20;  23: return 12'hB00;
            24: return 12'hB80;  25: return 12'h400;
            26: return 12'h420;  27: return 12'h440;
            28: return 12'h460;  29: return 12'h480;
            30: return 12'h4A0;  31: return 12'h4C0;
            32: return 12'h4E0;  33: return 12'h500;
            34: return 12'h520;  35: return 12'h540;
            36: return 12'h700;  37: return 12'h720;
            38: return 12'h740;  39: return 12'h760;
            40: return 12'h560;  41: return 12'h580;
            42: return 12'h5A0;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ipc_regs.sv
module ipc_regs
    import ipc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [DATA_W-1:0]                 rd_data_o,
    output logic [NUM_FIELDS-1:0][PRIO_W-1:0] fields_o,
    output logic [MASK_W-1:0]                 mask_o
);

    logic [NUM_LEG-1:0][REG_W-1:0] leg_q;
    logic [REG_W-1:0]              ext_q;
    logic [MASK_W-1:0]             mask_q;
    logic [NUM_LEG-1:0]            leg_hit;

    genvar k, f;
    generate
        for (k = 0; k < NUM_LEG; k++) begin : g_leg
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_LEG_BASE + ADDR_W'(4 * k);
            localparam logic [REG_W-1:0]  KEEP    = leg_keep(k);

            assign leg_hit[k] = (addr_i == MY_ADDR);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    leg_q[k] <= '0;
                end else if (wr_en_i && leg_hit[k]) begin
                    leg_q[k] <= wdata_i[REG_W-1:0] & KEEP;
                end
            end

            for (f = 0; f < FLD_PER_REG; f++) begin : g_fld
                assign fields_o[k*FLD_PER_REG + f] = leg_q[k][REG_W-1-f*PRIO_W -: PRIO_W];
            end
        end

        for (f = 0; f < FLD_PER_REG; f++) begin : g_ext_fld
            assign fields_o[EXT_FBASE + f] = ext_q[REG_W-1-f*PRIO_W -: PRIO_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q  <= '0;
            mask_q <= '0;
        end else if (wr_en_i) begin
            if (addr_i == ADDR_EXT)  ext_q  <= wdata_i[REG_W-1:0];
            if (addr_i == ADDR_MSET) mask_q <= mask_q | wdata_i[MASK_W-1:0];
            if (addr_i == ADDR_MCLR) mask_q <= mask_q & ~wdata_i[MASK_W-1:0];
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_LEG; i++) begin
            if (leg_hit[i]) rd_data_o[REG_W-1:0] = leg_q[i];
        end
        if (addr_i == ADDR_EXT)                          rd_data_o[REG_W-1:0]  = ext_q;
        if (addr_i == ADDR_MSET || addr_i == ADDR_MCLR)  rd_data_o[MASK_W-1:0] = mask_q;
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/ipc_prio_map.sv
module ipc_prio_map
    import ipc_pkg::*;
(
    input  logic [NUM_SRC-1:0]                req_i,
    input  logic [NUM_FIELDS-1:0][PRIO_W-1:0] fields_i,
    input  logic [MASK_W-1:0]                 mask_i,
    output logic [NUM_SRC-1:0]                elig_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_o
);

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_src
            localparam int FID  = src_field(i);
            localparam int MBIT = src_mask_bit(i);
            logic gate;

            if (MBIT >= 0) begin : g_masked
                assign gate = ~mask_i[MBIT];
            end else begin : g_open
                assign gate = 1'b1;
            end

            assign prio_o[i] = fields_i[FID];
            assign elig_o[i] = req_i[i] & gate & (fields_i[FID] != '0);
        end
    endgenerate

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter
    import ipc_pkg::*;
(
    input  logic [NUM_SRC-1:0]             elig_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           any_o,
    output logic [PRIO_W-1:0]              win_prio_o,
    output logic [CODE_W-1:0]              win_code_o
);

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        win_prio_o = '0;
        win_code_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i] && prio_i[i] >= win_prio_o) begin
                win_prio_o = prio_i[i];
                win_code_o = src_code(i);
            end
        end
    end

    assign any_o = |elig_i;

endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
    import ipc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   req_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 irq_o,
    output logic [PRIO_W-1:0]    irq_level_o,
    output logic [CODE_W-1:0]    irq_code_o
);

    logic [NUM_FIELDS-1:0][PRIO_W-1:0] fields;
    logic [MASK_W-1:0]                 mask_q;
    logic [NUM_SRC-1:0]                elig;
    logic [NUM_SRC-1:0][PRIO_W-1:0]    prio;
    logic                              any_elig;
    logic [PRIO_W-1:0]                 win_prio;
    logic [CODE_W-1:0]                 win_code;
    ipc_state_e                        state_q, state_d;

    ipc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rd_data_o (rd_data_o),
        .fields_o  (fields),
        .mask_o    (mask_q)
    );

    ipc_prio_map u_map (
        .req_i    (req_i),
        .fields_i (fields),
        .mask_i   (mask_q),
        .elig_o   (elig),
        .prio_o   (prio)
    );

    ipc_arbiter u_arb (
        .elig_i     (elig),
        .prio_i     (prio),
        .any_o      (any_elig),
        .win_prio_o (win_prio),
        .win_code_o (win_code)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_elig)  state_d = ST_RAISED;
            ST_RAISED: if (!any_elig) state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_level_o <= '0;
            irq_code_o  <= '0;
        end else if (state_d == ST_RAISED) begin
            irq_level_o <= win_prio;
            irq_code_o  <= win_code;
        end else begin
            irq_level_o <= '0;
            irq_code_o  <= '0;
        end
    end

    assign irq_o = (state_q == ST_RAISED);

endmodule

// File: rtl/ipc_ctrl_chk.sv
module ipc_ctrl_chk
    import ipc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   req_i,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [DATA_W-1:0]    wdata_i,
    input logic                 irq_o,
    input logic [PRIO_W-1:0]    irq_level_o,
    input logic [CODE_W-1:0]    irq_code_o,
    input logic                 any_elig,
    input logic [MASK_W-1:0]    mask_q
);

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(any_elig));

    assert_idle_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_i) |=> !irq_o);

    assert_level_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_level_o != '0);

    assert_quiet_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_level_o == '0 && irq_code_o == '0));

    assert_code_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_code_o[4:0] == 5'd0 && irq_code_o != '0));

    assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_MCLR) |=> ((mask_q & $past(wdata_i[MASK_W-1:0])) == '0));

    assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_MSET) |=>
            ((mask_q & $past(wdata_i[MASK_W-1:0])) == $past(wdata_i[MASK_W-1:0])));

endmodule

bind ipc_ctrl ipc_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .irq_o       (irq_o),
    .irq_level_o (irq_level_o),
    .irq_code_o  (irq_code_o),
    .any_elig    (any_elig),
    .mask_q      (mask_q)
);

// File: tb/ipc_ctrl_tb.sv
module ipc_ctrl_tb;

    localparam int NS = 43;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] req_i = '0;
    logic          wr_en_i = 1'b0;
    logic [7:0]    addr_i = '0;
    logic [31:0]   wdata_i = '0;
    logic [31:0]   rd_data_o;
    logic          irq_o;
    logic [3:0]    irq_level_o;
    logic [11:0]   irq_code_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    ipc_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .rd_data_o   (rd_data_o),
        .irq_o       (irq_o),
        .irq_level_o (irq_level_o),
        .irq_code_o  (irq_code_o)
    );

    // {req[59:17], irq[16], level[15:12], code[11:0]}
    localparam logic [59:0] VECS [0:15] = '{
        {43'h0,                             1'b0, 4'd0,  12'h000}, // R6
        {43'h1 << 25,                       1'b1, 4'd5,  12'h400}, // R5
        {(43'h1 << 25) | (43'h1 << 26),     1'b1, 4'd5,  12'h400}, // R8
        {(43'h1 << 25) | (43'h1 << 28),     1'b1, 4'd7,  12'h460}, // R3
        {(43'h1 << 27) | (43'h1 << 28),     1'b1, 4'd7,  12'h440}, // R8 tie in group
        {43'h1 << 1,                        1'b0, 4'd0,  12'h000}, // R6 zero field
        {(43'h1 << 2) | (43'h1 << 3),       1'b1, 4'd3,  12'h300}, // R8
        {(43'h1 << 14) | (43'h1 << 4),      1'b1, 4'd10, 12'h600}, // R2
        {(43'h1 << 15) | (43'h1 << 0),      1'b1, 4'd13, 12'hA00}, // R4
        {(43'h1 << 42) | (43'h1 << 17),     1'b1, 4'd6,  12'hAC0}, // R8 cross-group tie
        {(43'h1 << 40) | (43'h1 << 23),     1'b1, 4'd4,  12'hB00}, // R8
        {(43'h1 << 24) | (43'h1 << 13),     1'b1, 4'd11, 12'hB80}, // R4
        {(43'h1 << 36) | (43'h1 << 32),     1'b1, 4'd2,  12'h700}, // R2
        {43'h1 << 31,                       1'b1, 4'd2,  12'h4C0}, // R3
        {43'h1 << 5,                        1'b1, 4'd8,  12'h620}, // R5
        {43'h1 << 10,                       1'b1, 4'd9,  12'h780}  // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i  = a;
        wdata_i = d;
        wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        wdata_i = '0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string tag, input logic e_irq, input logic [3:0] e_lvl,
                             input logic [11:0] e_code);
        check({tag, " irq"},   {31'd0, irq_o},       {31'd0, e_irq});
        check({tag, " level"}, {28'd0, irq_level_o}, {28'd0, e_lvl});
        check({tag, " code"},  {20'd0, irq_code_o},  {20'd0, e_code});
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check_out("R1 reset", 1'b0, 4'd0, 12'h000);
        for (int a = 0; a < 4; a++) begin
            read_reg(8'(4 * a), rd);
            check("R1 legacy reg zero", rd, 32'h0);
        end
        read_reg(8'h40, rd); check("R1 ext reg zero", rd, 32'h0);
        read_reg(8'h80, rd); check("R1 mask zero", rd, 32'h0);
        // R6: requests with all priorities zero stay silent
        req_i = '1;
        settle();
        check_out("R6 all zero prio", 1'b0, 4'd0, 12'h000);
        req_i = '0;

        // R2 / R4 / R10: register storage and readback
        write_reg(8'h00, 32'hFFFF_5372);
        read_reg(8'h00, rd); check("R2 reg0 upper dropped", rd, 32'h0000_5372);
        write_reg(8'h04, 32'h0000_4611);
        read_reg(8'h04, rd); check("R2 unused field zero", rd, 32'h0000_4610);
        write_reg(8'h08, 32'h0000_892A);
        write_reg(8'h0C, 32'h0000_C033);
        read_reg(8'h0C, rd); check("R2 reg3", rd, 32'h0000_C033);
        write_reg(8'h40, 32'hFFFF_B46D);
        read_reg(8'h40, rd); check("R4 ext upper zero", rd, 32'h0000_B46D);
        write_reg(8'h10, 32'hFFFF_FFFF);
        read_reg(8'h10, rd); check("R10 unmapped read", rd, 32'h0);
        for (int a = 0; a < 4; a++) begin
            read_reg(8'(4 * a), rd);
            check("R10 unmapped write no effect",
                  rd, (a == 0) ? 32'h5372 : (a == 1) ? 32'h4610 :
                      (a == 2) ? 32'h892A : 32'hC033);
        end
        write_reg(8'h80, 32'hFFFF_FFFF);
        read_reg(8'h80, rd); check("R7 mask set", rd, 32'h0000_03FF);
        read_reg(8'hA0, rd); check("R7 mask via clear addr", rd, 32'h0000_03FF);
        write_reg(8'hA0, 32'hFFFF_FFFF);
        read_reg(8'h80, rd); check("R7 mask clear", rd, 32'h0);

        // Vector table walk: R3 R5 R8
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            req_i = VECS[v][59:17];
            settle();
            check_out($sformatf("R8 vector %0d", v), VECS[v][16], VECS[v][15:12], VECS[v][11:0]);
        end

        // R7: masking an extended source
        @(negedge clk);
        req_i = (43'h1 << 15) | (43'h1 << 0);
        settle();
        check_out("R7 unmasked serr", 1'b1, 4'd13, 12'hA00);
        write_reg(8'h80, 32'h0000_0001);
        settle();
        check_out("R7 serr masked", 1'b1, 4'd12, 12'h240);
        write_reg(8'h80, 32'h0000_03FF);
        @(negedge clk);
        req_i = 43'h1 << 25;
        settle();
        check_out("R7 mask leaves legacy", 1'b1, 4'd5, 12'h400);
        @(negedge clk);
        req_i = 43'h1 << 24;
        settle();
        check_out("R7 timer4 masked", 1'b0, 4'd0, 12'h000);
        write_reg(8'hA0, 32'h0000_0200);
        settle();
        check_out("R7 timer4 unmasked", 1'b1, 4'd11, 12'hB80);
        write_reg(8'hA0, 32'h0000_03FF);

        // R3: group members follow a shared field rewrite
        write_reg(8'h00, 32'h0000_5392);
        @(negedge clk);
        req_i = 43'h1 << 28;
        settle();
        check_out("R3 group member 28", 1'b1, 4'd9, 12'h460);
        @(negedge clk);
        req_i = 43'h1 << 27;
        settle();
        check_out("R3 group member 27", 1'b1, 4'd9, 12'h440);

        // R6: zeroing a field disables its source
        write_reg(8'h00, 32'h0000_0392);
        @(negedge clk);
        req_i = 43'h1 << 25;
        settle();
        check_out("R6 timer0 disabled", 1'b0, 4'd0, 12'h000);
        write_reg(8'h00, 32'h0000_5372);
        @(negedge clk);
        req_i = '0;
        settle();

        // R9: one-cycle latency and level-sensitive release
        @(negedge clk);
        req_i = 43'h1 << 25;
        #1;
        check("R9 not yet raised", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        check_out("R9 raised after one edge", 1'b1, 4'd5, 12'h400);
        req_i = '0;
        #1;
        check("R9 still held", {31'd0, irq_o}, 32'd1);
        @(negedge clk);
        check_out("R9 dropped after release", 1'b0, 4'd0, 12'h000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule